// File: doc/BRIEF.md
# Shared Forward/Inverse Byte Substitution Unit

This block is a purely combinational 8-bit substitution unit. It computes either the AES forward S-box or the AES inverse S-box on a single datapath, and a one-bit mode input selects which one. Both directions share the same multiplicative-inverse core. The core works in the composite field GF((2^4)^2), using a polynomial basis over GF(2^4) with x^4+x+1.

A byte enters the unit in one of two ways:
- In inverse mode, the byte first passes through the inverse affine stage.
- In forward mode, the byte enters the field mapping directly.

The mapping into the composite field is a linear bit-matrix transform. The inversion there has three parts:
1. A first stage forms the norm-like nibble.
2. A GF(2^4) inverter inverts that nibble.
3. A combining stage forms the two output nibbles.

The inverse bit-matrix then returns the result to the standard field. In forward mode the result then passes through the affine stage; in inverse mode it leaves as it is. The two basis-change matrices are derived at elaboration from a root of the standard field polynomial, so the mapping is an exact field isomorphism.

In a clocked design, the unit sits between registers and gives one substitution result per cycle.

Top module: `sbox_shared`

## Requirements
- R1: `inv_sel` = 0 selects forward substitution and `inv_sel` = 1 selects inverse substitution. Both use the same inversion logic.
- R2: In forward mode, `data_out` equals the AES S-box of `data_in` for all 256 inputs. The S-box is defined as the GF(2^8) inverse modulo 0x11B, with 0 mapped to 0, followed by the affine map b ^ rotl1(b) ^ rotl2(b) ^ rotl3(b) ^ rotl4(b) ^ 0x63.
- R3: In inverse mode, `data_out` equals the inverse AES S-box of `data_in` for all 256 inputs.
- R4: In forward mode, input 0x00 yields 0x63, because the composite-field inversion maps zero to zero.
- R5: In inverse mode, input 0x63 yields 0x00.
- R6: For every byte x, feeding the forward output back in inverse mode returns x.
- R7: For any nonzero composite-field operand, the inversion core returns an element whose composite-field product with the operand is 1.
- R8: The output is a combinational function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 8 | Byte to substitute |
| inv_sel | input | 1 | 0 = forward S-box, 1 = inverse S-box |
| data_out | output | 8 | Substituted byte |

## Verification
The block holds no state, so a wrong internal value shows at the port in the same evaluation as the input that exposes it. The possible faults show up in these ways:
- A wrong constant, a wrong basis-change column or a wrong nibble product corrupts specific output bytes. Exhaustive sweeps in both modes catch every such byte.
- Swapping the mode wiring, or applying an affine stage on the wrong side, breaks the 0x00/0x63 corner pair.
- Either of those faults also breaks the forward-then-inverse round trip for nearly every byte.

// File: rtl/sbox_shared.sv
module sbox_shared (
  input  logic [7:0] data_in,
  input  logic       inv_sel,
  output logic [7:0] data_out
);

  function automatic logic [3:0] nib_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p, t;
    p = 4'h0;
    t = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ t;
      t = t[3] ? ({t[2:0], 1'b0} ^ 4'h3) : {t[2:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [3:0] nib_sq(input logic [3:0] a);
    return nib_mul(a, a);
  endfunction

  function automatic logic [3:0] nib_inv(input logic [3:0] a);
    logic [3:0] a2, a4, a8;
    a2 = nib_sq(a);
    a4 = nib_sq(a2);
    a8 = nib_sq(a4);
    return nib_mul(nib_mul(a2, a4), a8);
  endfunction

  function automatic logic [3:0] pick_lambda();
    for (int k = 1; k < 16; k++) begin
      logic ok;
      ok = 1'b1;
      for (int t = 0; t < 16; t++)
        if ((nib_sq(4'(t)) ^ 4'(t) ^ 4'(k)) == 4'h0) ok = 1'b0;
      if (ok) return 4'(k);
    end
    return 4'h0;
  endfunction

  function automatic logic [7:0] cf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [3:0] lam);
    logic [3:0] hh;
    hh = nib_mul(a[7:4], b[7:4]);
    return {hh ^ nib_mul(a[7:4], b[3:0]) ^ nib_mul(a[3:0], b[7:4]),
            nib_mul(hh, lam) ^ nib_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [7:0] find_root(input logic [3:0] lam);
    for (int c = 2; c < 256; c++) begin
      logic [7:0] pw, acc;
      pw  = 8'h01;
      acc = 8'h00;
      for (int i = 0; i < 9; i++) begin
        if (i == 0 || i == 1 || i == 3 || i == 4 || i == 8) acc = acc ^ pw;
        pw = cf_mul(pw, 8'(c), lam);
      end
      if (acc == 8'h00) return 8'(c);
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] mat_apply(input logic [63:0] m, input logic [7:0] v);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < 8; i++)
      if (v[i]) acc = acc ^ m[i*8 +: 8];
    return acc;
  endfunction

  function automatic logic [63:0] build_iso(input logic [3:0] lam);
    logic [63:0] m;
    logic [7:0]  r, pw;
    r  = find_root(lam);
    pw = 8'h01;
    m  = 64'h0;
    for (int i = 0; i < 8; i++) begin
      m[i*8 +: 8] = pw;
      pw = cf_mul(pw, r, lam);
    end
    return m;
  endfunction

  function automatic logic [63:0] build_inv(input logic [63:0] m);
    logic [63:0] r;
    r = 64'h0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (mat_apply(m, 8'(a)) == (8'h01 << j)) r[j*8 +: 8] = 8'(a);
    return r;
  endfunction

  function automatic logic [7:0] fwd_affine(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_affine(input logic [7:0] b);
    logic [7:0] y, o;
    y = b ^ 8'h63;
    for (int i = 0; i < 8; i++)
      o[i] = y[(i+2)%8] ^ y[(i+5)%8] ^ y[(i+7)%8];
    return o;
  endfunction

  localparam logic [3:0]  LAM     = pick_lambda();
  localparam logic [63:0] ISO     = build_iso(LAM);
  localparam logic [63:0] ISO_INV = build_inv(ISO);

  logic [7:0] pre, iso_v, cf_out, back;
  logic [3:0] hi, lo, delta, delta_inv;

  assign pre   = inv_sel ? inv_affine(data_in) : data_in;
  assign iso_v = mat_apply(ISO, pre);
  assign hi    = iso_v[7:4];
  assign lo    = iso_v[3:0];

  assign delta     = nib_mul(nib_sq(hi), LAM) ^ nib_mul(hi, lo) ^ nib_sq(lo);
  assign delta_inv = nib_inv(delta);

  assign cf_out = {nib_mul(hi, delta_inv), nib_mul(hi ^ lo, delta_inv)};
  assign back   = mat_apply(ISO_INV, cf_out);

  assign data_out = inv_sel ? back : fwd_affine(back);

  always_comb begin
    a_r7_core_product: assert (iso_v == 8'h00 || cf_mul(iso_v, cf_out, LAM) == 8'h01)
      else $error("composite inverse product not one");
    a_r4_zero_to_zero: assert (iso_v != 8'h00 || cf_out == 8'h00)
      else $error("inversion of zero not zero");
    a_r4_fwd_zero: assert (inv_sel || data_in != 8'h00 || data_out == 8'h63)
      else $error("forward 00 not 63");
    a_r5_inv_63: assert (!inv_sel || data_in != 8'h63 || data_out == 8'h00)
      else $error("inverse 63 not 00");
    a_r1_iso_roundtrip: assert (mat_apply(ISO_INV, iso_v) == pre)
      else $error("basis change not invertible");
  end

endmodule

// File: tb/test_sbox_shared.sv
module test_sbox_shared;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic       inv_sel = 1'b0;
  logic [7:0] data_out;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [7:0] fwd_ref [256];
  logic [7:0] inv_ref [256];

  always #5 clk = ~clk;

  sbox_shared i_sbox_shared (
    .data_in (data_in),
    .inv_sel (inv_sel),
    .data_out(data_out)
  );

  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7C}, {1'b0, 8'h02, 8'h77},
    {1'b0, 8'h53, 8'hED}, {1'b0, 8'hFF, 8'h16}, {1'b0, 8'h10, 8'hCA},
    {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7C, 8'h01}, {1'b1, 8'hED, 8'h53},
    {1'b1, 8'h16, 8'hFF}
  };

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, t;
    p = 0; t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= t;
      t = t[7] ? ({t[6:0], 1'b0} ^ 8'h1B) : {t[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  task automatic apply(input logic sel, input logic [7:0] x);
    @(negedge clk);
    inv_sel = sel;
    data_in = x;
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (data_out !== exp) begin
      errors++;
      $display("FAIL %s: in=%h sel=%b got %h expected %h", req, data_in, inv_sel, data_out, exp);
    end
  endtask

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv, s;
      iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (x != 0 && gmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      s = iv ^ rotl(iv, 1) ^ rotl(iv, 2) ^ rotl(iv, 3) ^ rotl(iv, 4) ^ 8'h63;
      fwd_ref[x] = s;
      inv_ref[s] = 8'(x);
    end

    #1;
    checks++;
    if (data_out !== 8'h63) begin
      errors++;
      $display("FAIL R8: output at start got %h expected 63", data_out);
    end
    repeat (2) @(posedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][16], VEC[k][15:8]);
      check(VEC[k][16] ? "R5 known inverse" : "R4 known forward", VEC[k][7:0]);
    end

    for (int x = 0; x < 256; x++) begin
      apply(1'b0, 8'(x));
      check("R2 forward sweep", fwd_ref[x]);
    end
    for (int x = 0; x < 256; x++) begin
      apply(1'b1, 8'(x));
      check("R3 inverse sweep", inv_ref[x]);
    end

    for (int x = 0; x < 256; x++) begin
      logic [7:0] f;
      apply(1'b0, 8'(x));
      f = data_out;
      apply(1'b1, f);
      check("R6 round trip", 8'(x));
    end

    apply(1'b0, 8'h63);
    check("R1 mode zero forward", 8'hFB);
    inv_sel = 1'b1;
    #1;
    check("R1 mode one inverse", 8'h00);
    data_in = 8'h00;
    #1;
    check("R8 combinational follow", 8'h52);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule